// File: doc/BRIEF.md
# Output Denormalization and Clamp Stage

This stage sits at the tail of a colour pipeline. It takes pixels whose three components are signed fixed-point numbers normalized so that 1.0 means full intensity, and it turns each component into an unsigned integer code for the selected output depth. For 8, 10 and 12-bit depths the value is scaled by (2^N-1)/2^N, rounded to N bits and clamped, so that an input of exactly 1.0 lands on the largest code, 2^N-1, rather than overflowing to 2^N.

A small control register, written through a one-cycle write strobe, holds the depth mode and a packing flag. The flag chooses whether codes narrower than the 12-bit output field sit at its low end (flag set) or are shifted up to its top (flag clear). Pixels enter and leave on valid/ready streams through a two-stage pipeline that stalls as a whole when the consumer is not ready.

Top module: `denorm_clamp`

## Requirements
- R1: After reset, out_valid is low, in_ready is high, the mode is bypass (0) and the packing flag is clear.
- R2: Mode 1 (8-bit): each component x (signed, FRAC_W fraction bits, 1.0 = 2^FRAC_W) becomes y = x - (x >>> 8), then (y + 2^(FRAC_W-9)) >>> (FRAC_W-8); an input of 1.0 gives 255.
- R3: Mode 2 (10-bit): same with N = 10; an input of 1.0 gives 1023.
- R4: Mode 3 (12-bit): same with N = 12; an input of 1.0 gives 4095.
- R5: Mode 0 (bypass): no scaling and no rounding; the code is x >>> (FRAC_W-12), clamped to 0..4095.
- R6: Every result is clamped to 0..2^N-1; negative inputs give 0, inputs above 1.0 give the maximum code, and nothing wraps.
- R7: With the packing flag clear, 8-bit codes are shifted left by 4 and 10-bit codes by 2 in the 12-bit field; with it set, codes are right-aligned. Bypass and 12-bit codes are never shifted.
- R8: A control write with cfg_depth 0..3 sets the mode to that value; a write with cfg_depth 4..7 leaves the mode unchanged but still updates the packing flag.
- R9: A pixel accepted at clock edge k appears on out_valid/out_pix at edge k+2 when out_ready has been high.
- R10: While out_valid is high and out_ready is low, out_valid stays high, out_pix holds its value and in_ready is low.
- R11: The three components are processed independently; component c occupies in_pix[c*IN_W +: IN_W] and out_pix[c*12 +: 12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_depth | input | 3 | Depth code: 0 bypass, 1 8-bit, 2 10-bit, 3 12-bit, 4-7 keep mode |
| cfg_pack10 | input | 1 | Packing flag: 1 right-aligned, 0 left-justified |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | NCOMP*IN_W | Three signed normalized components |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer ready |
| out_pix | output | NCOMP*12 | Three unsigned output codes |

## Verification
On every cycle the assertions watch the stream contract: a stalled output holds its data and blocks the input, an accepted pixel emerges two edges later, a write with an out-of-range depth code leaves the mode register alone, and right-aligned 8-bit codes never set the top four bits of a field. The arithmetic itself (the exact codes produced by scaling, rounding, clamping and justification in each mode, including full scale, half scale and out-of-range inputs) is only shown by the bench's directed scenarios, which compare each component against values computed from the requirements.

// File: rtl/denorm_pkg.sv
package denorm_pkg;

    localparam int OUT_W = 12;

    typedef enum logic [1:0] {
        DM_PASS = 2'd0,
        DM_D8   = 2'd1,
        DM_D10  = 2'd2,
        DM_D12  = 2'd3
    } dmode_e;

    function automatic int depth_bits(dmode_e m);
        case (m)
            DM_D8:   return 8;
            DM_D10:  return 10;
            default: return 12;
        endcase
    endfunction

endpackage

// File: rtl/denorm_cfg.sv
module denorm_cfg
    import denorm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_i,
    input  logic [2:0] depth_i,
    input  logic       pack10_i,
    output dmode_e     mode_o,
    output logic       pack10_o
);

    typedef struct packed {
        dmode_e mode;
        logic   pack10;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_i) begin
            cfg_d.pack10 = pack10_i;
            if (!depth_i[2]) begin
                cfg_d.mode = dmode_e'(depth_i[1:0]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '{mode: DM_PASS, pack10: 1'b0};
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign mode_o   = cfg_q.mode;
    assign pack10_o = cfg_q.pack10;

endmodule

// File: rtl/denorm_lane.sv
module denorm_lane
    import denorm_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [IN_W-1:0]  x_i,
    input  dmode_e           mode_s0_i,
    input  dmode_e           mode_s1_i,
    input  logic             pack10_s1_i,
    output logic [OUT_W-1:0] code_o
);

    localparam int WW = IN_W + 1;

    typedef struct packed {
        logic [IN_W-1:0]  y;
        logic [OUT_W-1:0] code;
    } lane_t;

    lane_t lane_d, lane_q;

    logic signed [IN_W-1:0] xs;
    logic signed [IN_W-1:0] y_new;
    logic signed [WW-1:0]   yw, rnd, lim, sum, rsh;
    logic [OUT_W-1:0]       code_new;
    int                     nb, sh;

    always_comb begin
        // stage 1: scale by (2^N-1)/2^N as x - (x >>> N)
        xs = $signed(x_i);
        if (mode_s0_i == DM_PASS) begin
            y_new = xs;
        end else begin
            y_new = xs - (xs >>> depth_bits(mode_s0_i));
        end

        // stage 2: round to N bits, clamp, justify
        nb  = depth_bits(mode_s1_i);
        sh  = FRAC_W - nb;
        yw  = {lane_q.y[IN_W-1], lane_q.y};
        rnd = (mode_s1_i == DM_PASS) ? '0 : (WW'(1) << (sh - 1));
        lim = WW'((1 << nb) - 1);
        sum = yw + rnd;
        rsh = sum >>> sh;
        if (rsh < 0) begin
            code_new = '0;
        end else if (rsh > lim) begin
            code_new = lim[OUT_W-1:0];
        end else begin
            code_new = rsh[OUT_W-1:0];
        end
        if (!pack10_s1_i) begin
            code_new = code_new << (OUT_W - nb);
        end

        lane_d.y    = y_new;
        lane_d.code = code_new;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lane_q <= '0;
        end else if (en) begin
            lane_q <= lane_d;
        end
    end

    assign code_o = lane_q.code;

endmodule

// File: rtl/denorm_clamp.sv
module denorm_clamp
    import denorm_pkg::*;
#(
    parameter int IN_W   = 16,
    parameter int FRAC_W = 14,
    parameter int NCOMP  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cfg_wr,
    input  logic [2:0]             cfg_depth,
    input  logic                   cfg_pack10,
    input  logic                   in_valid,
    output logic                   in_ready,
    input  logic [NCOMP*IN_W-1:0]  in_pix,
    output logic                   out_valid,
    input  logic                   out_ready,
    output logic [NCOMP*OUT_W-1:0] out_pix
);

    typedef struct packed {
        logic   v1;
        dmode_e m1;
        logic   p1;
        logic   v2;
        dmode_e m2;
        logic   p2;
    } pipe_t;

    pipe_t  pipe_d, pipe_q;
    dmode_e cfg_mode;
    logic   cfg_pack;
    logic   adv;
    dmode_e out_mode;
    logic   out_pack;

    denorm_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (cfg_wr),
        .depth_i  (cfg_depth),
        .pack10_i (cfg_pack10),
        .mode_o   (cfg_mode),
        .pack10_o (cfg_pack)
    );

    assign adv = !pipe_q.v2 || out_ready;

    always_comb begin
        pipe_d = pipe_q;
        if (adv) begin
            pipe_d.v1 = in_valid;
            pipe_d.m1 = cfg_mode;
            pipe_d.p1 = cfg_pack;
            pipe_d.v2 = pipe_q.v1;
            pipe_d.m2 = pipe_q.m1;
            pipe_d.p2 = pipe_q.p1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    for (genvar c = 0; c < NCOMP; c++) begin : g_lane
        denorm_lane #(
            .IN_W   (IN_W),
            .FRAC_W (FRAC_W)
        ) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (adv),
            .x_i         (in_pix[c*IN_W +: IN_W]),
            .mode_s0_i   (cfg_mode),
            .mode_s1_i   (pipe_q.m1),
            .pack10_s1_i (pipe_q.p1),
            .code_o      (out_pix[c*OUT_W +: OUT_W])
        );
    end

    assign in_ready  = adv;
    assign out_valid = pipe_q.v2;
    assign out_mode  = pipe_q.m2;
    assign out_pack  = pipe_q.p2;

endmodule

// File: rtl/denorm_clamp_chk.sv
module denorm_clamp_chk
    import denorm_pkg::*;
#(
    parameter int NCOMP = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   in_valid,
    input logic                   in_ready,
    input logic                   out_valid,
    input logic                   out_ready,
    input logic [NCOMP*OUT_W-1:0] out_pix,
    input logic                   cfg_wr,
    input logic [2:0]             cfg_depth,
    input dmode_e                 cfg_mode,
    input dmode_e                 out_mode,
    input logic                   out_pack
);

    logic high_set;

    always_comb begin
        high_set = 1'b0;
        for (int c = 0; c < NCOMP; c++) begin
            high_set = high_set | (|out_pix[c*OUT_W+8 +: OUT_W-8]);
        end
    end

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pix)); // R10

    AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |-> !in_ready); // R10

    AST_TWO_CYCLE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_ready, 2) && $past(in_ready) |-> out_valid); // R9

    AST_BAD_DEPTH_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr && cfg_depth[2] |=> $stable(cfg_mode)); // R8

    AST_CODE_FITS_8BIT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_mode == DM_D8 && out_pack |-> !high_set); // R6

endmodule

bind denorm_clamp denorm_clamp_chk #(.NCOMP(NCOMP)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_pix   (out_pix),
    .cfg_wr    (cfg_wr),
    .cfg_depth (cfg_depth),
    .cfg_mode  (cfg_mode),
    .out_mode  (out_mode),
    .out_pack  (out_pack)
);

// File: tb/sim_denorm_clamp.sv
module sim_denorm_clamp;

    localparam int IN_W   = 16;
    localparam int FRAC_W = 14;
    localparam int NCOMP  = 3;
    localparam int OUT_W  = 12;
    localparam int ONE    = 1 << FRAC_W;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   cfg_wr = 1'b0;
    logic [2:0]             cfg_depth = '0;
    logic                   cfg_pack10 = 1'b0;
    logic                   in_valid = 1'b0;
    logic                   in_ready;
    logic [NCOMP*IN_W-1:0]  in_pix = '0;
    logic                   out_valid;
    logic                   out_ready = 1'b1;
    logic [NCOMP*OUT_W-1:0] out_pix;

    int n_checks = 0;
    int n_fail   = 0;
    int m_mode   = 0;
    bit m_pack   = 1'b0;

    always #2 clk = ~clk;

    denorm_clamp #(.IN_W(IN_W), .FRAC_W(FRAC_W), .NCOMP(NCOMP)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_depth(cfg_depth),
        .cfg_pack10(cfg_pack10), .in_valid(in_valid), .in_ready(in_ready),
        .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready),
        .out_pix(out_pix)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model(input int x, input int m, input bit p);
        int n, sh, y, r, lim;
        if (m == 0) begin
            n = 12;
            r = x >>> (FRAC_W - 12);
        end else begin
            n  = (m == 1) ? 8 : (m == 2) ? 10 : 12;
            sh = FRAC_W - n;
            y  = x - (x >>> n);
            r  = (y + (1 << (sh - 1))) >>> sh;
        end
        lim = (1 << n) - 1;
        if (r < 0) r = 0;
        if (r > lim) r = lim;
        if (!p) r = r << (12 - n);
        return r;
    endfunction

    task automatic set_cfg(input int depth, input bit pack);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_depth = 3'(depth); cfg_pack10 = pack;
        @(negedge clk);
        cfg_wr = 1'b0;
        if (depth < 4) m_mode = depth;
        m_pack = pack;
    endtask

    // push one pixel and check its codes; returns component 0 code
    task automatic push(input int c0, input int c1, input int c2, input string req,
                        output int got0);
        int xs[3];
        xs = '{c0, c1, c2};
        @(negedge clk);
        in_pix = {IN_W'(c2), IN_W'(c1), IN_W'(c0)};
        in_valid = 1'b1;
        chk(in_ready == 1'b1, "R9", int'(in_ready), 1);
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b0, "R9", int'(out_valid), 0);
        @(negedge clk);
        chk(out_valid == 1'b1, "R9", int'(out_valid), 1);
        for (int c = 0; c < NCOMP; c++) begin
            int act, exp;
            act = int'(out_pix[c*OUT_W +: OUT_W]);
            exp = model(xs[c], m_mode, m_pack);
            chk(act == exp, req, act, exp);
        end
        got0 = int'(out_pix[OUT_W-1:0]);
    endtask

    task automatic t_reset();
        int g;
        chk(out_valid == 1'b0, "R1", int'(out_valid), 0);
        chk(in_ready == 1'b1, "R1", int'(in_ready), 1);
        push(ONE, ONE/2, 0, "R1", g);           // bypass after reset: 1.0 clamps to 4095
        chk(g == 4095, "R1", g, 4095);
    endtask

    task automatic t_depth8();
        int g;
        set_cfg(1, 1'b1);
        push(ONE, ONE/2, ONE/4, "R2", g);
        chk(g == 255, "R2", g, 255);
        push(ONE/2, 100, 12345, "R11", g);
        chk(g == 128, "R2", g, 128);
    endtask

    task automatic t_depth10();
        int g;
        set_cfg(2, 1'b1);
        push(ONE, 333, ONE*3/4, "R3", g);
        chk(g == 1023, "R3", g, 1023);
    endtask

    task automatic t_depth12();
        int g;
        set_cfg(3, 1'b1);
        push(ONE, 7, ONE/3, "R4", g);
        chk(g == 4095, "R4", g, 4095);
    endtask

    task automatic t_bypass();
        int g;
        set_cfg(0, 1'b1);
        push(16'h1234, 3, ONE - 1, "R5", g);
        chk(g == 1165, "R5", g, 1165);
    endtask

    task automatic t_clamp();
        int g;
        for (int m = 0; m < 4; m++) begin
            set_cfg(m, 1'b1);
            push(32767, -32768, -1, "R6", g);
            chk(g == ((m == 1) ? 255 : (m == 2) ? 1023 : 4095), "R6", g,
                (m == 1) ? 255 : (m == 2) ? 1023 : 4095);
        end
    endtask

    task automatic t_justify();
        int g;
        set_cfg(1, 1'b0);
        push(ONE, ONE/2, 0, "R7", g);
        chk(g == 12'hFF0, "R7", g, 12'hFF0);
        set_cfg(3, 1'b0);
        push(ONE, 1000, 2, "R7", g);
        chk(g == 4095, "R7", g, 4095);
    endtask

    task automatic t_bad_depth();
        int g;
        set_cfg(2, 1'b1);
        set_cfg(5, 1'b0);                       // mode stays 10-bit, flag clears
        push(ONE, 50, ONE/8, "R8", g);
        chk(g == 12'hFFC, "R8", g, 12'hFFC);
    endtask

    task automatic t_stall();
        logic [NCOMP*OUT_W-1:0] held;
        int exp0;
        set_cfg(1, 1'b1);
        exp0 = model(ONE/2, 1, 1'b1);
        @(negedge clk);
        out_ready = 1'b0;
        in_pix = {IN_W'(1), IN_W'(ONE), IN_W'(ONE/2)};
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b1, "R10", int'(out_valid), 1);
        chk(in_ready == 1'b0, "R10", int'(in_ready), 0);
        held = out_pix;
        chk(int'(held[OUT_W-1:0]) == exp0, "R10", int'(held[OUT_W-1:0]), exp0);
        @(negedge clk);
        @(negedge clk);
        chk(out_valid == 1'b1, "R10", int'(out_valid), 1);
        chk(out_pix == held, "R10", int'(out_pix[OUT_W-1:0]), int'(held[OUT_W-1:0]));
        out_ready = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", int'(out_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_depth8();
        t_depth10();
        t_depth12();
        t_bypass();
        t_clamp();
        t_justify();
        t_bad_depth();
        t_stall();
        @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(4 * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule